// File: doc/BRIEF.md
# Weight-Stationary Systolic FIR Array

This block computes a finite convolution with a row of identical multiply-accumulate cells that all run on one clock. Each cell keeps one coefficient. Input samples enter the far end of the row and move one cell per clock toward the near end. Partial sums start at zero in the near-end cell and move one cell per clock the other way. Because the two streams move in opposite directions, a sample meets a given partial sum in exactly one cell. That cell adds the sample times its coefficient to the sum and registers the result.

A sample is presented with a valid flag. Valid samples must be at least one idle cycle apart. An idle cycle counts as a zero sample, so gaps of any length are allowed. For every valid sample the finished sum appears on the next cycle with its own valid flag. Coefficients come from a parameter at reset and can be rewritten one at a time through a small write port.

Top module: `sc_conv_array`

## Requirements
- R1: A sample moves one cell per clock, unchanged, so coefficient c[i] meets the sample that entered 2·i cycles before the sample that completes the sum.
- R2: For a valid sample entering in cycle t, the result is y = Σ c[i]·X(t−2i) over i = 0..N_CELLS−1. X(k) is the sample value in cycle k, or zero if that cycle was idle or came before reset was released.
- R3: The partial sum entering the first cell is zero, so a lone sample x after a quiet interval yields exactly c[0]·x.
- R4: Valid samples are never on consecutive cycles, and gaps of any length are allowed. As a result, sum_vld_o is never high on two consecutive cycles.
- R5: sum_vld_o is high on exactly the cycle after each valid sample and is low in every other cycle.
- R6: Asserting rst_ni low clears every sample, sum and flag register. Later results use an all-zero history.
- R7: When cf_we_i is high at a clock edge, cf_dat_i is written into coefficient slot cf_idx_i. A write made when no valid sample has entered in the previous 2·N_CELLS−1 cycles governs every later result.
- R8: At reset, coefficient slot i takes bits [COEF_W·i+COEF_W−1 : COEF_W·i] of INIT_COEF. With the defaults this gives c[i] = i+1.
- R9: The 18-bit result is exact at full scale. For example, four terms of (−128)·(−128) give 65536, and four terms of 127·(−128) give −65024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for all cells |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Marks the sample in this cycle as valid |
| smp_i | input | SMP_W (8) | Signed input sample |
| cf_we_i | input | 1 | Coefficient write strobe |
| cf_idx_i | input | IDX_W (2) | Coefficient slot to write |
| cf_dat_i | input | COEF_W (8) | Signed coefficient value |
| sum_vld_o | output | 1 | Marks sum_o as a finished result |
| sum_o | output | ACC_W (18) | Signed convolution result |

## Verification
The assertions assume two things about the inputs. First, smp_vld_i never stays high for two cycles in a row. Second, coefficients are only rewritten while no valid sample is still moving through the row. The stimulus drives every sample through a task that always follows a valid sample with at least one idle cycle, and it sometimes leaves longer gaps of two or three idle cycles. Before every coefficient load it inserts 2·N_CELLS idle cycles. The reference model keeps a per-cycle history in which idle cycles are zero. It computes each expected sum from the R2 formula, including the case where reset is applied in the middle of a stream.

// File: rtl/sc_conv_pkg.sv
package sc_conv_pkg;
  localparam int unsigned CELLS     = 4;
  localparam int unsigned SMP_BITS  = 8;
  localparam int unsigned COEF_BITS = 8;

  localparam logic [CELLS-1:0][COEF_BITS-1:0] DEF_COEF = {8'd4, 8'd3, 8'd2, 8'd1};

  // bits for an exact sum of n products
  function automatic int unsigned acc_width(int unsigned sw, int unsigned cw, int unsigned n);
    return sw + cw + ((n > 1) ? $clog2(n) : 1);
  endfunction

  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sc_coef_bank.sv
module sc_coef_bank #(
  parameter int unsigned N_CELLS = 4,
  parameter int unsigned COEF_W  = 8,
  parameter int unsigned IDX_W   = 2,
  parameter logic [N_CELLS-1:0][COEF_W-1:0] INIT_COEF = '0
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [COEF_W-1:0]                dat_i,
  output logic [N_CELLS-1:0][COEF_W-1:0]   coef_o
);

  for (genvar i = 0; i < N_CELLS; i++) begin : g_slot
    logic [COEF_W-1:0] coef_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              coef_q <= INIT_COEF[i];
      else if (we_i && (idx_i == IDX_W'(i)))    coef_q <= dat_i;
    end

    assign coef_o[i] = coef_q;
  end

endmodule

// File: rtl/sc_conv_cell.sv
module sc_conv_cell #(
  parameter int unsigned SMP_W  = 8,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned ACC_W  = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic signed [SMP_W-1:0]  x_i,
  input  logic                     x_vld_i,
  input  logic signed [ACC_W-1:0]  ps_i,
  output logic signed [SMP_W-1:0]  x_o,
  output logic                     x_vld_o,
  output logic signed [ACC_W-1:0]  ps_o
);

  localparam int unsigned PROD_W = SMP_W + COEF_W;
  localparam int unsigned PAD_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] x_ext, c_ext, prod;
  logic signed [ACC_W-1:0]  prod_ext, ps_d;
  logic signed [SMP_W-1:0]  x_q;
  logic                     x_vld_q;
  logic signed [ACC_W-1:0]  ps_q;

  always_comb begin
    x_ext    = {{COEF_W{x_i[SMP_W-1]}}, x_i};
    c_ext    = {{SMP_W{coef_i[COEF_W-1]}}, coef_i};
    // idle slots contribute nothing
    prod     = x_vld_i ? (x_ext * c_ext) : '0;
    prod_ext = {{PAD_W{prod[PROD_W-1]}}, prod};
    ps_d     = ps_i + prod_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q     <= '0;
      x_vld_q <= 1'b0;
      ps_q    <= '0;
    end else begin
      x_q     <= x_i;
      x_vld_q <= x_vld_i;
      ps_q    <= ps_d;
    end
  end

  assign x_o     = x_q;
  assign x_vld_o = x_vld_q;
  assign ps_o    = ps_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_vld_i && (ps_i[ACC_W-1] == prod_ext[ACC_W-1])) |-> (ps_d[ACC_W-1] == ps_i[ACC_W-1])); // R9

endmodule

// File: rtl/sc_conv_array.sv
module sc_conv_array
  import sc_conv_pkg::*;
#(
  parameter int unsigned N_CELLS = CELLS,
  parameter int unsigned SMP_W   = SMP_BITS,
  parameter int unsigned COEF_W  = COEF_BITS,
  parameter logic [N_CELLS-1:0][COEF_W-1:0] INIT_COEF = DEF_COEF,
  localparam int unsigned ACC_W  = acc_width(SMP_W, COEF_W, N_CELLS),
  localparam int unsigned IDX_W  = idx_width(N_CELLS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_vld_i,
  input  logic signed [SMP_W-1:0]  smp_i,
  input  logic                     cf_we_i,
  input  logic [IDX_W-1:0]         cf_idx_i,
  input  logic signed [COEF_W-1:0] cf_dat_i,
  output logic                     sum_vld_o,
  output logic signed [ACC_W-1:0]  sum_o
);

  logic [N_CELLS-1:0][COEF_W-1:0] coef;

  // sample stream: entry at index N_CELLS, moves toward index 1
  logic signed [SMP_W-1:0] x_bus     [N_CELLS:1];
  logic                    x_vld_bus [N_CELLS:1];
  // partial sums: cell k output, moves toward higher k
  logic signed [ACC_W-1:0] ps_bus    [N_CELLS];
  logic signed [SMP_W-1:0] unused_x_dat;
  logic                    unused_x_vld;

  assign x_bus[N_CELLS]     = smp_i;
  assign x_vld_bus[N_CELLS] = smp_vld_i;

  sc_coef_bank #(
    .N_CELLS  (N_CELLS),
    .COEF_W   (COEF_W),
    .IDX_W    (IDX_W),
    .INIT_COEF(INIT_COEF)
  ) u_coef (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cf_we_i),
    .idx_i (cf_idx_i),
    .dat_i (cf_dat_i),
    .coef_o(coef)
  );

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    logic signed [SMP_W-1:0] x_out;
    logic                    x_vld_out;
    logic signed [ACC_W-1:0] ps_in;

    // cell k holds the tap applied 2*(N_CELLS-1-k) cycles back
    sc_conv_cell #(
      .SMP_W (SMP_W),
      .COEF_W(COEF_W),
      .ACC_W (ACC_W)
    ) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .coef_i ($signed(coef[N_CELLS-1-k])),
      .x_i    (x_bus[k+1]),
      .x_vld_i(x_vld_bus[k+1]),
      .ps_i   (ps_in),
      .x_o    (x_out),
      .x_vld_o(x_vld_out),
      .ps_o   (ps_bus[k])
    );

    if (k == 0) begin : g_head
      assign ps_in        = '0;
      assign unused_x_dat = x_out;
      assign unused_x_vld = x_vld_out;

      AST_CELL0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !x_vld_bus[1] |=> (ps_bus[0] == '0)); // R3
    end else begin : g_body
      assign ps_in        = ps_bus[k-1];
      assign x_bus[k]     = x_out;
      assign x_vld_bus[k] = x_vld_out;
    end

    AST_X_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      x_vld_bus[k+1] |=> (x_vld_out && (x_out == $past(x_bus[k+1])))); // R1
  end

  assign sum_o     = ps_bus[N_CELLS-1];
  assign sum_vld_o = g_cell[N_CELLS-1].x_vld_out;

  AST_IN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i |=> !smp_vld_i); // R4

  AST_OUT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_vld_o |=> !sum_vld_o); // R4

endmodule

// File: tb/tb_sc_conv_array.sv
module tb_sc_conv_array;
  localparam int N  = 4;
  localparam int SW = 8;
  localparam int CW = 8;
  localparam int AW = 18;
  localparam int IW = 2;
  localparam int HL = 2 * N - 1;

  logic                 clk_i = 1'b0;
  logic                 rst_ni;
  logic                 smp_vld_i;
  logic signed [SW-1:0] smp_i;
  logic                 cf_we_i;
  logic [IW-1:0]        cf_idx_i;
  logic signed [CW-1:0] cf_dat_i;
  logic                 sum_vld_o;
  logic signed [AW-1:0] sum_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  sc_conv_array dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_vld_i(smp_vld_i),
    .smp_i    (smp_i),
    .cf_we_i  (cf_we_i),
    .cf_idx_i (cf_idx_i),
    .cf_dat_i (cf_dat_i),
    .sum_vld_o(sum_vld_o),
    .sum_o    (sum_o)
  );

  int    coef_m [N];
  int    hist   [HL];
  int    exp_q  [$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    pend  = 1'b0;
  string cur_req = "R2";
  logic [15:0] lf = 16'hACE1;

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic shift_hist(int v);
    for (int j = HL - 1; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = v;
  endtask

  // driver: one cycle of stimulus, pushes the expected result
  task automatic tick(bit v, int val);
    int e;
    @(negedge clk_i); #1;
    smp_vld_i = v;
    smp_i     = SW'(val);
    cf_we_i   = 1'b0;
    shift_hist(v ? val : 0);
    if (v) begin
      e = 0;
      for (int i = 0; i < N; i++) e += coef_m[i] * hist[2*i];
      exp_q.push_back(e);
    end
    pend = v;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 0);
  endtask

  task automatic load(int idx, int val);
    @(negedge clk_i); #1;
    smp_vld_i = 1'b0;
    cf_we_i   = 1'b1;
    cf_idx_i  = IW'(idx);
    cf_dat_i  = CW'(val);
    shift_hist(0);
    coef_m[idx] = val;
    pend = 1'b0;
  endtask

  task automatic reset_all();
    for (int j = 0; j < HL; j++) hist[j] = 0;
    for (int i = 0; i < N; i++) coef_m[i] = i + 1;  // R8 default
    exp_q.delete();
    pend = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i); #1;
    rst_ni    = 1'b0;
    smp_vld_i = 1'b0;
    cf_we_i   = 1'b0;
    reset_all();
    repeat (2) @(negedge clk_i);
    chk("R6", int'(sum_vld_o), 0);
    chk("R6", int'(sum_o), 0);
    #1 rst_ni = 1'b1;
  endtask

  task automatic step_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  // monitor: valid timing every cycle, values against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni === 1'b1) begin
      chk("R5", int'(sum_vld_o), int'(pend));
      if (sum_vld_o === 1'b1) begin
        if (exp_q.size() == 0) begin
          n_vec++;
          n_bad++;
          $display("FAIL R5: actual valid with empty scoreboard, expected idle (t=%0t)", $time);
        end else begin
          chk(cur_req, int'(sum_o), exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; smp_vld_i = 1'b0; smp_i = '0;
    cf_we_i = 1'b0; cf_idx_i = '0; cf_dat_i = '0;
    reset_all();
    repeat (3) @(negedge clk_i);
    chk("R6", int'(sum_vld_o), 0);   // reset state
    chk("R6", int'(sum_o), 0);
    #1 rst_ni = 1'b1;
    idle(2);

    // R3 / R8: impulse reads out the default taps in order
    cur_req = "R3";
    tick(1'b1, 1); idle(1);
    cur_req = "R8";
    for (int i = 0; i < N + 1; i++) begin tick(1'b1, 0); idle(1); end
    idle(4);

    // R1 / R2: ramp at minimum spacing
    cur_req = "R2";
    for (int i = 1; i <= 12; i++) begin tick(1'b1, i); idle(1); end
    cur_req = "R1";
    for (int i = 0; i < 8; i++) begin tick(1'b1, (i % 2) ? -50 : 37); idle(1); end
    idle(2 * N);

    // R7: reload with mixed signs, then impulse and ramp
    cur_req = "R7";
    load(0, -3); load(1, 5); load(2, -7); load(3, 2);
    idle(2);
    tick(1'b1, 1); idle(1);
    for (int i = 0; i < N + 1; i++) begin tick(1'b1, 0); idle(1); end
    for (int i = 0; i < 10; i++) begin tick(1'b1, 9 - 3 * i); idle(1); end
    idle(2 * N);

    // R4: irregular gaps, idle cycles count as zero samples
    cur_req = "R4";
    for (int i = 0; i < 60; i++) begin
      step_lf();
      tick(1'b1, int'($signed(lf[7:0])));
      idle(1 + int'(lf[9:8]) % 3);
    end
    idle(2 * N);

    // R9: full-scale sums
    cur_req = "R9";
    for (int i = 0; i < N; i++) load(i, -128);
    idle(1);
    for (int i = 0; i < N + 2; i++) begin tick(1'b1, -128); idle(1); end
    idle(2 * N);
    for (int i = 0; i < N; i++) load(i, 127);
    idle(1);
    for (int i = 0; i < N + 2; i++) begin tick(1'b1, -128); idle(1); end
    for (int i = 0; i < 6; i++) begin tick(1'b1, (i % 2) ? 127 : -128); idle(1); end
    idle(2 * N);

    // R6: reset in the middle of a stream, history must be cleared
    cur_req = "R6";
    for (int i = 0; i < 5; i++) begin tick(1'b1, 100 - 7 * i); idle(1); end
    tick(1'b1, 77);
    do_reset();
    tick(1'b1, 5); idle(1);
    cur_req = "R8";
    for (int i = 0; i < N + 1; i++) begin tick(1'b1, 0); idle(1); end
    for (int i = 0; i < 6; i++) begin tick(1'b1, -i * 11); idle(1); end
    idle(2 * N);

    chk("R5", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule